// File: doc/BRIEF.md
# Spread-Spectrum Divide-Ratio Modulator

This block drives the feedback divider of a fractional-N clock synthesizer that has to spread its output spectrum. Every reference cycle it emits an integer divide ratio. Averaged over time, that ratio follows a programmed nominal value minus a slowly varying offset. The offset comes from a built-in triangle generator. The generator starts at zero offset, steps toward a fixed maximum, then steps back to zero, and repeats. Because the offset is only ever subtracted, the synthesized frequency is pulled below nominal and never above it.

The fractional part of the offset-corrected ratio feeds a third-order noise-shaping modulator. The modulator is built from three cascaded first-order accumulators. Their overflow bits are recombined into a small signed increment, and that increment is added to the integer part. The quantization error is therefore pushed to high frequencies, where the loop filter removes it.

With the default settings, one triangle period lasts 832 reference cycles. That gives about 30 kHz from a 25 MHz reference. The peak depth is 5000 ppm of a ratio of 48. When spreading is turned off, the offset returns to zero and the synthesizer runs at its plain programmed ratio.

Top module: `sscg_divctl`

## Requirements
- R1: While `rst_n` is low, `ratio_o` and `profile_o` are both zero.
- R2: In the cycle after `spread_en` is sampled low, `profile_o` is zero.
- R3: While `spread_en` is sampled high, `profile_o` changes by exactly STEP (605 by default) at every clock edge, either up or down.
- R4: `profile_o` never exceeds PEAK = STEP·HALF (251680 by default, in units of 2^-20 of the ratio).
- R5: The profile climbs from 0 to PEAK in HALF edges and falls back to 0 in another HALF edges. Direction reverses exactly at PEAK and exactly at 0, so the period is 2·HALF edges.
- R6: After `spread_en` rises from low, the first enabled edge sets `profile_o` to STEP, so a sweep always starts from zero offset.
- R7: `ratio_o` stays within ±4 of the integer ratio applied one cycle earlier. The increment lies in −3..+4, and the offset borrows at most one from the integer part.
- R8: With spreading off and a zero fractional input, `ratio_o` equals `nom_int_i` in every cycle from the first edge after reset.
- R9: With spreading off and a fractional input F, the sum of `ratio_o` over any 64 consecutive cycles is within 4 of 64·(`nom_int_i` + F/2^20).
- R10: With spreading on, the sum of `ratio_o` over any 2·HALF consecutive cycles is within 4 of 2·HALF·(`nom_int_i` + `nom_frac_i`/2^20) − STEP·HALF²/2^20. In other words, the mean equals the nominal ratio minus half the peak offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en | input | 1 | High enables the triangle sweep; low holds the offset at zero |
| nom_int_i | input | INT_W | Integer part of the nominal divide ratio |
| nom_frac_i | input | ACC_W | Fractional part of the nominal ratio, in units of 2^-ACC_W |
| ratio_o | output | INT_W | Instantaneous integer divide ratio for this reference cycle |
| profile_o | output | ACC_W | Present down-spread offset, in units of 2^-ACC_W |

## Verification
A corrupted triangle state shows up at `profile_o` on the very next edge. A wrong step, a missed turn or a late reset of the offset breaks the ±STEP rule or the zero-after-disable rule within one cycle. A corrupted accumulator or carry delay behaves differently. It seldom breaks the per-cycle range of `ratio_o`, but it biases the running sum. The bench therefore compares sums of `ratio_o` over one full triangle period, and over a 64-cycle window with spreading off, against the exact expected mean. Those checks catch a cancellation-network error within one window.

// File: rtl/sscg_pkg.sv
package sscg_pkg;
  localparam int MASH_ORDER = 3;
  localparam int INC_W      = 4;
  typedef logic signed [INC_W-1:0] inc_t;
endpackage

// File: rtl/sscg_tri_profile.sv
module sscg_tri_profile #(
  parameter int ACC_W = 20,
  parameter int STEP  = 605,
  parameter int HALF  = 416
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             en_i,
  output logic [ACC_W-1:0] ofs_o
);
  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);
  localparam logic [ACC_W-1:0] PEAK_V = ACC_W'(STEP * HALF);

  logic [ACC_W-1:0] ofs_q, ofs_d;
  logic             rise_q, rise_d;

  // next state: turn exactly when an end point is reached
  always_comb begin
    ofs_d  = ofs_q;
    rise_d = rise_q;
    if (!en_i) begin
      ofs_d  = '0;
      rise_d = 1'b1;
    end else if (rise_q) begin
      ofs_d  = ofs_q + STEP_V;
      rise_d = (ofs_d != PEAK_V);
    end else begin
      ofs_d  = ofs_q - STEP_V;
      rise_d = (ofs_d == '0);
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q  <= '0;
      rise_q <= 1'b1;
    end else begin
      ofs_q  <= ofs_d;
      rise_q <= rise_d;
    end
  end

  assign ofs_o = ofs_q;
endmodule

// File: rtl/sscg_mash3.sv
module sscg_mash3
  import sscg_pkg::*;
#(
  parameter int ACC_W = 20
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] frac_i,
  output inc_t             inc_o
);
  logic [MASH_ORDER-1:0][ACC_W-1:0] acc_q, acc_d;
  logic [MASH_ORDER-1:0]            cy;
  logic [ACC_W-1:0]                 feed;
  logic                             c2_q, c3_q, c3_qq;

  // cascade: each stage integrates the residue of the one before
  always_comb begin
    feed = frac_i;
    for (int k = 0; k < MASH_ORDER; k++) begin
      {cy[k], acc_d[k]} = {1'b0, acc_q[k]} + {1'b0, feed};
      feed = acc_d[k];
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      c2_q  <= 1'b0;
      c3_q  <= 1'b0;
      c3_qq <= 1'b0;
    end else begin
      acc_q <= acc_d;
      c2_q  <= cy[1];
      c3_q  <= cy[2];
      c3_qq <= c3_q;
    end
  end

  // error cancellation: c1 + (1-z^-1)c2 + (1-z^-1)^2 c3
  always_comb begin
    inc_o = inc_t'({3'b000, cy[0]})
          + inc_t'({3'b000, cy[1]}) - inc_t'({3'b000, c2_q})
          + inc_t'({3'b000, cy[2]}) - inc_t'({2'b00, c3_q, 1'b0})
          + inc_t'({3'b000, c3_qq});
  end
endmodule

// File: rtl/sscg_divctl.sv
module sscg_divctl
  import sscg_pkg::*;
#(
  parameter int INT_W = 8,
  parameter int ACC_W = 20,
  parameter int STEP  = 605,
  parameter int HALF  = 416
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             spread_en,
  input  logic [INT_W-1:0] nom_int_i,
  input  logic [ACC_W-1:0] nom_frac_i,
  output logic [INT_W-1:0] ratio_o,
  output logic [ACC_W-1:0] profile_o
);
  localparam int W = INT_W + ACC_W;

  logic [ACC_W-1:0] ofs;
  logic [W-1:0]     eff;
  inc_t             inc;
  logic [INT_W-1:0] ratio_d, ratio_q;

  sscg_tri_profile #(.ACC_W(ACC_W), .STEP(STEP), .HALF(HALF)) u_prof (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .en_i    (spread_en),
    .ofs_o   (ofs)
  );

  // down spread: offset only ever subtracted, borrow reaches integer part
  assign eff = {nom_int_i, nom_frac_i} - W'(ofs);

  sscg_mash3 #(.ACC_W(ACC_W)) u_mash (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .frac_i  (eff[ACC_W-1:0]),
    .inc_o   (inc)
  );

  always_comb begin
    ratio_d = eff[W-1:ACC_W] + {{(INT_W-INC_W){inc[INC_W-1]}}, inc};
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) ratio_q <= '0;
    else        ratio_q <= ratio_d;
  end

  assign ratio_o   = ratio_q;
  assign profile_o = ofs;
endmodule

// File: rtl/sscg_divctl_chk.sv
module sscg_divctl_chk #(
  parameter int INT_W = 8,
  parameter int ACC_W = 20,
  parameter int STEP  = 605,
  parameter int HALF  = 416
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             spread_en,
  input logic [INT_W-1:0] nom_int_i,
  input logic [INT_W-1:0] ratio_o,
  input logic [ACC_W-1:0] profile_o
);
  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);
  localparam logic [ACC_W-1:0] PEAK_V = ACC_W'(STEP * HALF);

  logic armed;
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    if (!rst_n) begin
      assert_reset_zero_R1: assert (ratio_o == '0 && profile_o == '0);
    end
  end

  assert_off_clears_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !spread_en |=> profile_o == '0);

  assert_step_size_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    spread_en |=> (profile_o == $past(profile_o) + STEP_V) ||
                  (profile_o == $past(profile_o) - STEP_V));

  assert_bound_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    profile_o <= PEAK_V);

  assert_turn_at_peak_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (spread_en && profile_o == PEAK_V) |=> profile_o == PEAK_V - STEP_V);

  assert_restart_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(spread_en) |=> profile_o == STEP_V);

  assert_ratio_range_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    armed |-> (int'(ratio_o) >= int'($past(nom_int_i)) - 4) &&
              (int'(ratio_o) <= int'($past(nom_int_i)) + 4));
endmodule

bind sscg_divctl sscg_divctl_chk #(
  .INT_W(INT_W), .ACC_W(ACC_W), .STEP(STEP), .HALF(HALF)
) i_chk (
  .clk_ref   (clk_ref),
  .rst_n     (rst_n),
  .spread_en (spread_en),
  .nom_int_i (nom_int_i),
  .ratio_o   (ratio_o),
  .profile_o (profile_o)
);

// File: tb/test_sscg_divctl.sv
`timescale 1ns/1ps
module test_sscg_divctl;
  localparam int INT_W = 8;
  localparam int ACC_W = 20;
  localparam int STEP  = 605;
  localparam int HALF  = 416;
  localparam longint PEAK = longint'(STEP) * HALF;
  localparam longint ONE  = longint'(1) << ACC_W;

  logic             clk, rst_n, spread_en;
  logic [INT_W-1:0] nom_int;
  logic [ACC_W-1:0] nom_frac;
  logic [INT_W-1:0] ratio;
  logic [ACC_W-1:0] profile;

  int     errors = 0;
  int     checks = 0;
  bit     done   = 0;
  logic [ACC_W-1:0] exp_q[$];
  longint m_ofs  = 0;
  bit     m_up   = 1;
  bit     acc_on = 0;
  bit     range_on = 0;
  longint acc_sum = 0;
  int     acc_n  = 0;
  logic [INT_W-1:0] last_ratio;
  logic [ACC_W-1:0] last_prof;

  sscg_divctl #(.INT_W(INT_W), .ACC_W(ACC_W), .STEP(STEP), .HALF(HALF)) i_sscg_divctl (
    .clk_ref   (clk),
    .rst_n     (rst_n),
    .spread_en (spread_en),
    .nom_int_i (nom_int),
    .nom_frac_i(nom_frac),
    .ratio_o   (ratio),
    .profile_o (profile)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: read last results, apply enable, push expected profile
  task automatic step(input logic en);
    @(negedge clk);
    last_ratio = ratio;
    last_prof  = profile;
    if (range_on)
      check(int'(last_ratio) >= int'(nom_int) - 4 && int'(last_ratio) <= int'(nom_int) + 4,
            "R7 ratio range", longint'(last_ratio), longint'(nom_int));
    if (acc_on) begin
      acc_sum += longint'(last_ratio);
      acc_n++;
    end
    spread_en = en;
    if (!en) begin
      m_ofs = 0; m_up = 1;
    end else if (m_up) begin
      m_ofs += STEP;
      if (m_ofs == PEAK) m_up = 0;
    end else begin
      m_ofs -= STEP;
      if (m_ofs == 0) m_up = 1;
    end
    exp_q.push_back(ACC_W'(m_ofs));
  endtask

  // monitor: compare profile right after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [ACC_W-1:0] e;
        e = exp_q.pop_front();
        check(profile == e, "R3 profile step", longint'(profile), longint'(e));
        check(longint'(profile) <= PEAK, "R4 profile bound", longint'(profile), PEAK);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; spread_en = 1'b0; nom_int = 8'd48; nom_frac = '0;
    repeat (3) @(negedge clk);
    check(ratio == '0, "R1 ratio in reset", longint'(ratio), 0);
    check(profile == '0, "R1 profile in reset", longint'(profile), 0);
    rst_n = 1'b1;

    // R8: integer-only, spreading off
    for (int i = 0; i < 20; i++) begin
      step(1'b0);
      check(last_ratio == nom_int, "R8 constant ratio", longint'(last_ratio), longint'(nom_int));
    end

    // R9: fractional, spreading off
    nom_frac = 20'h60000;
    step(1'b0); step(1'b0); step(1'b0);
    range_on = 1;
    acc_sum = 0; acc_n = 0; acc_on = 1;
    for (int i = 0; i < 64; i++) step(1'b0);
    acc_on = 0;
    begin
      longint expv, act;
      expv = 64 * (longint'(nom_int) * ONE + longint'(nom_frac));
      act  = acc_sum * ONE;
      check(act - expv < 4 * ONE && expv - act < 4 * ONE, "R9 mean unspread", act, expv);
    end

    // R5: one triangle from zero, turns at PEAK and 0
    for (int j = 1; j <= 2 * HALF + 1; j++) begin
      step(1'b1);
      if (j == 2)        check(last_prof == ACC_W'(STEP), "R6 first step", longint'(last_prof), STEP);
      if (j == HALF + 1) check(longint'(last_prof) == PEAK, "R5 peak reached", longint'(last_prof), PEAK);
      if (j == HALF + 2) check(longint'(last_prof) == PEAK - STEP, "R5 reverse at peak", longint'(last_prof), PEAK - STEP);
      if (j == 2 * HALF + 1) check(last_prof == '0, "R5 back to zero", longint'(last_prof), 0);
    end

    // R10: mean over one full period
    acc_sum = 0; acc_n = 0; acc_on = 1;
    for (int i = 0; i < 2 * HALF; i++) step(1'b1);
    acc_on = 0;
    begin
      longint expv, act;
      expv = longint'(2 * HALF) * (longint'(nom_int) * ONE + longint'(nom_frac))
             - longint'(STEP) * HALF * HALF;
      act  = acc_sum * ONE;
      check(act - expv < 4 * ONE && expv - act < 4 * ONE, "R10 mean spread", act, expv);
    end

    // R2 / R6: stop mid-sweep, then restart
    for (int i = 0; i < 57; i++) step(1'b1);
    step(1'b0);
    step(1'b1);
    check(last_prof == '0, "R2 cleared on disable", longint'(last_prof), 0);
    step(1'b1);
    check(last_prof == ACC_W'(STEP), "R6 restart from zero", longint'(last_prof), STEP);
    for (int i = 0; i < 5; i++) step(1'b1);

    @(posedge clk); #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule